// File: doc/BRIEF.md
# Oscillator Clock Controller with Periodic Time Base

This block runs on the oscillator clock and serves two purposes. It produces a CPU clock-enable that is high every cycle in normal operation, or a single-cycle pulse every 2, 4, 8 or 16 oscillator cycles in slow operation. It also contains a programmable time-base counter. At the end of each period the counter sets a sticky flag, and the flag raises an interrupt when interrupts are enabled. The counter period is fixed, so it can serve as a real-time clock.

Software sees one 8-bit control/status byte. The byte is always visible on the read-data port. A write strobe loads the writable fields, and a read strobe acknowledges the flag. A separate output enables the main-clock-out pin function. Two power-mode inputs control the block:
- Full halt freezes everything.
- Active halt keeps the time base counting only while the interrupt enable is set, and ignores writes in both cases.

The external reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `osc_timebase_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, the interrupt and clock-out enable are low, and the CPU enable is high every cycle.
- R2: With bit 4 (slow select) at 0 and no halt input active, the CPU enable is high in every cycle.
- R3: With bit 4 at 1, the CPU enable pulses for one cycle every N cycles, where N is 2, 4, 8 or 16 for bits 6:5 equal to 00, 01, 10 or 11. A write that changes bits 6:4 restarts the count, so the first pulse falls in the Nth cycle after the write takes effect.
- R4: Bits 3:2 select the time-base period. The defaults are 16000, 32000, 80000 and 200000 oscillator cycles for 00 to 11, and each is set by a parameter.
- R5: A new period selection is used only after the period already running has completed.
- R6: Each period end sets bit 0 (flag). Writes never change bit 0, and the flag stays set until it is acknowledged.
- R7: A read strobe clears the flag on the next edge. If a period ends in that same cycle, the flag stays set.
- R8: The interrupt output is high exactly while bit 0 and bit 1 (interrupt enable) are both set. It falls in the cycle after the flag is cleared.
- R9: The clock-out enable output follows bit 7.
- R10: While full halt is high, the counter, the divider and the whole byte are frozen. Writes and read strobes are ignored, and the CPU enable is low.
- R11: While active halt is high with bit 1 set, the time base keeps counting. Writes are ignored and the CPU enable is low.
- R12: While active halt is high with bit 1 clear, the time base holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control byte |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe; acknowledges the flag |
| rd_data_o | output | 8 | Current control/status byte |
| halt_i | input | 1 | Full halt mode |
| active_halt_i | input | 1 | Active halt mode |
| cpu_ce_o | output | 1 | CPU clock-enable |
| clk_out_en_o | output | 1 | Main-clock-out pin function enable |
| irq_o | output | 1 | Time-base interrupt request |

## Verification
The checker watches several properties on every cycle:
- the interrupt tracks the flag and enable bits;
- the clock-out enable tracks bit 7;
- the byte is frozen under full halt and its writable bits under active halt;
- the CPU enable is suppressed in either halt;
- the flag is sticky until acknowledged;
- no two slow-mode pulses are adjacent.

Other behaviours only the bench scenarios can show, because they are matters of exact period lengths and cycle positions:
- the divider phase after a restart;
- each selectable period;
- the deferral of a period change;
- the extra length a frozen counter adds to a period;
- the acknowledge that collides with a period end.

// File: rtl/otc_pkg.sv
package otc_pkg;

  // Control/status byte, bit 7 down to bit 0.
  typedef struct packed {
    logic       clk_out;   // 7
    logic [1:0] div_sel;   // 6:5
    logic       slow;      // 4
    logic [1:0] tb_sel;    // 3:2
    logic       ie;        // 1
    logic       flag;      // 0
  } ctl_t;

  // Divider count width covers the largest ratio (16).
  localparam int unsigned DIV_W = 4;

  function automatic logic [DIV_W-1:0] div_last(input logic [1:0] sel);
    return DIV_W'((2 << sel) - 1);
  endfunction

endpackage

// File: rtl/otc_regs.sv
module otc_regs
  import otc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic       upd_ok,
  input  logic       ovf,
  output ctl_t       ctl,
  output logic       cfg_chg
);

  ctl_t cur_q, nxt;
  logic wr_acc, rd_acc;

  assign wr_acc = wr_en & upd_ok;
  assign rd_acc = rd_en & upd_ok;

  always_comb begin
    nxt     = cur_q;
    cfg_chg = 1'b0;
    if (wr_acc) begin
      nxt.clk_out = wr_data[7];
      nxt.div_sel = wr_data[6:5];
      nxt.slow    = wr_data[4];
      nxt.tb_sel  = wr_data[3:2];
      nxt.ie      = wr_data[1];
      cfg_chg     = (wr_data[6:4] != {cur_q.div_sel, cur_q.slow});
    end
    if (ovf)
      nxt.flag = 1'b1;
    else if (rd_acc)
      nxt.flag = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt;
  end

  assign ctl = cur_q;

endmodule

// File: rtl/otc_cpu_div.sv
module otc_cpu_div
  import otc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       slow,
  input  logic [1:0] div_sel,
  input  logic       restart,
  output logic       ce
);

  logic [DIV_W-1:0] cnt_q, cnt_d, last;
  logic             at_last;

  assign last    = div_last(div_sel);
  assign at_last = (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)
      cnt_d = '0;
    else if (run && slow)
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ce = run & (~slow | at_last);

endmodule

// File: rtl/otc_timebase.sv
module otc_timebase #(
  parameter int unsigned CNT_W = 18,
  parameter int unsigned PER0  = 16000,
  parameter int unsigned PER1  = 32000,
  parameter int unsigned PER2  = 80000,
  parameter int unsigned PER3  = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] tb_sel,
  output logic       ovf
);

  localparam int unsigned NSEL = 4;

  logic [CNT_W-1:0] last_tab [NSEL];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       act_q, act_d;

  for (genvar g = 0; g < NSEL; g++) begin : g_last
    localparam int unsigned PER = (g == 0) ? PER0 : (g == 1) ? PER1 :
                                  (g == 2) ? PER2 : PER3;
    assign last_tab[g] = CNT_W'(PER - 1);
  end

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    ovf   = 1'b0;
    if (run) begin
      if (cnt_q == last_tab[act_q]) begin
        ovf   = 1'b1;
        cnt_d = '0;
        act_d = tb_sel;   // new selection only at period end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

endmodule

// File: rtl/osc_timebase_ctrl.sv
module osc_timebase_ctrl
  import otc_pkg::*;
#(
  parameter int unsigned CNT_W = 18,
  parameter int unsigned PER0  = 16000,
  parameter int unsigned PER1  = 32000,
  parameter int unsigned PER2  = 80000,
  parameter int unsigned PER3  = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_en_i,
  output logic [7:0] rd_data_o,
  input  logic       halt_i,
  input  logic       active_halt_i,
  output logic       cpu_ce_o,
  output logic       clk_out_en_o,
  output logic       irq_o
);

  logic [1:0] rs_q;
  logic       rst_sync_n;
  ctl_t       ctl;
  logic       cfg_chg, ovf, upd_ok, cnt_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign upd_ok  = ~halt_i & ~active_halt_i;
  assign cnt_run = ~halt_i & (~active_halt_i | ctl.ie);

  otc_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en_i),
    .wr_data (wr_data_i),
    .rd_en   (rd_en_i),
    .upd_ok  (upd_ok),
    .ovf     (ovf),
    .ctl     (ctl),
    .cfg_chg (cfg_chg)
  );

  otc_cpu_div u_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (upd_ok),
    .slow    (ctl.slow),
    .div_sel (ctl.div_sel),
    .restart (cfg_chg),
    .ce      (cpu_ce_o)
  );

  otc_timebase #(
    .CNT_W (CNT_W),
    .PER0  (PER0),
    .PER1  (PER1),
    .PER2  (PER2),
    .PER3  (PER3)
  ) u_tb (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (cnt_run),
    .tb_sel (ctl.tb_sel),
    .ovf    (ovf)
  );

  assign rd_data_o    = ctl;
  assign clk_out_en_o = ctl.clk_out;
  assign irq_o        = ctl.flag & ctl.ie;

endmodule

// File: rtl/otc_chk.sv
module otc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       halt_i,
  input logic       active_halt_i,
  input logic [7:0] rd_data,
  input logic       cpu_ce,
  input logic       clk_out_en,
  input logic       irq
);

  // R9
  mco_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out_en == rd_data[7]);

  // R8
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rd_data[0] & rd_data[1]));

  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> $stable(rd_data));

  // R11
  ahalt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_halt_i |=> $stable(rd_data[7:1]));

  // R10 R11
  ce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i || active_halt_i) |-> !cpu_ce);

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && !rd_en) |=> rd_data[0]);

  // R3
  ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[4] && cpu_ce && !wr_en) |=> !cpu_ce);

endmodule

bind osc_timebase_ctrl otc_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .wr_en         (wr_en_i),
  .rd_en         (rd_en_i),
  .halt_i        (halt_i),
  .active_halt_i (active_halt_i),
  .rd_data       (rd_data_o),
  .cpu_ce        (cpu_ce_o),
  .clk_out_en    (clk_out_en_o),
  .irq           (irq_o)
);

// File: tb/sim_osc_timebase_ctrl.sv
module sim_osc_timebase_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int P0 = 12;
  localparam int P1 = 20;
  localparam int P2 = 28;
  localparam int P3 = 40;

  logic       clk, rst_n, wr_en, rd_en, halt, ahalt;
  logic [7:0] wr_data, rd_data;
  logic       cpu_ce, clk_out_en, irq;
  int         total, bad, cyc;

  osc_timebase_ctrl #(.CNT_W(6), .PER0(P0), .PER1(P1), .PER2(P2), .PER3(P3)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .halt_i(halt),
    .active_halt_i(ahalt), .cpu_ce_o(cpu_ce), .clk_out_en_o(clk_out_en),
    .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int per_of(input int t);
    return (t == 0) ? P0 : (t == 1) ? P1 : (t == 2) ? P2 : P3;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_flag(output int st);
    while (rd_data[0] !== 1'b1) @(negedge clk);
    st = cyc;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0, s1, s2, errs, cnt;
    total = 0; bad = 0; cyc = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = 8'h00;
    halt = 1'b0; ahalt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 byte", rd_data, 8'h00);
    check("R1 irq/clkout", {irq, clk_out_en}, 0);
    check("R1 ce", cpu_ce, 1);

    // R2 normal rate
    cnt = 0;
    for (int k = 0; k < 16; k++) begin cnt += cpu_ce; @(negedge clk); end
    check("R2 ce count", cnt, 16);

    // R9 clock-out enable
    wr(8'h80);
    check("R9 set", clk_out_en, 1);
    wr(8'h00);
    check("R9 clear", clk_out_en, 0);

    // R3 slow-mode ratios and restart phase
    for (int cp = 0; cp < 4; cp++) begin
      int n;
      n = 2 << cp;
      wr({1'b0, 2'(cp), 1'b1, 4'b0000});
      errs = 0;
      for (int k = 1; k <= 4 * n; k++) begin
        if (cpu_ce !== ((k % n) == 0)) errs++;
        @(negedge clk);
      end
      check($sformatf("R3 ratio %0d mismatches", n), errs, 0);
    end
    wr(8'h00);
    check("R2 ce after slow off", cpu_ce, 1);

    // R6 / R8 / R7 flag handling (TB=0, OIE=0)
    wait_flag(s0);
    wr(8'h01);
    check("R6 flag not writable", rd_data[0], 0);
    while (rd_data[0] !== 1'b1) @(negedge clk);
    check("R8 irq masked", irq, 0);
    wr(8'h00);
    check("R6 write keeps flag", rd_data[0], 1);
    wr(8'h02);
    check("R8 irq asserted", irq, 1);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    check("R7 read clears", rd_data[0], 0);
    check("R8 irq drops", irq, 0);

    // R7 read colliding with period end
    wait_flag(s0);
    repeat (P0 - 2) @(negedge clk);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    check("R7 overflow wins", rd_data[0], 1);
    wait_flag(s0);

    // R4 each period
    for (int t = 0; t < 4; t++) begin
      wr(8'((t << 2) | 2));
      wait_flag(s0); wait_flag(s1); wait_flag(s2);
      check($sformatf("R4 period sel %0d", t), s2 - s1, per_of(t));
    end

    // R5 deferred selection change (currently sel 3)
    wait_flag(s0);
    wr(8'h02);
    wait_flag(s1); wait_flag(s2);
    check("R5 old period kept", s1 - s0, P3);
    check("R5 new period next", s2 - s1, P0);

    // R10 full halt
    wait_flag(s0);
    halt = 1'b1; wr_en = 1'b1; wr_data = 8'hFF;
    errs = 0;
    for (int k = 0; k < 30; k++) begin
      rd_en = 1'b1;
      @(negedge clk);
      if (cpu_ce !== 1'b0) errs++;
    end
    halt = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    check("R10 ce low", errs, 0);
    check("R10 byte frozen", rd_data, 8'h02);
    wait_flag(s1);
    check("R10 counter frozen", s1 - s0, P0 + 30);

    // R11 active halt, enable set
    wait_flag(s0);
    ahalt = 1'b1; wr_en = 1'b1; wr_data = 8'hFC;
    errs = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (cpu_ce !== 1'b0) errs++;
    end
    ahalt = 1'b0; wr_en = 1'b0;
    check("R11 ce low", errs, 0);
    check("R11 write ignored", {rd_data[7:1], 1'b0}, 8'h02);
    wait_flag(s1);
    check("R11 counter runs", s1 - s0, P0);

    // R12 active halt, enable clear
    wr(8'h00);
    wait_flag(s0);
    ahalt = 1'b1;
    repeat (20) @(negedge clk);
    ahalt = 1'b0;
    wait_flag(s1);
    check("R12 counter held", s1 - s0, P0 + 20);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule